// File: doc/BRIEF.md
# Page-Splitting Block DMA Engine

A single-channel block mover that a processor programs through four memory-mapped words. Software writes a word-aligned physical memory address and a byte count, then writes the control word with its start bit set. The engine asks for the system bus and, after the arbiter grants it, moves one data word per cycle between a device-side data port and memory. It takes no help from the processor until the whole block has moved.

Addresses are physical, so no burst may run past the end of a page. When a burst reaches the last word of a page, the engine drops its bus request for one cycle so that other masters can win arbitration. It then asks again and continues on the next page. The processor is signalled once, at the end of the block or on a rejected start. It is not signalled for each word. The interrupt is a level that stays high until software clears the flag that caused it.

Top module: `dma_engine`

## Requirements
- R1: After reset, all four register words read zero and busReq, memEn and irq are low.
- R2: Register words are selected by regSel: 0 = memory address, 1 = byte count (LEN_W bits), 2 = control (bit0 start, bit1 direction, bit2 interrupt enable), 3 = status (bit0 busy, bit1 done, bit2 error). The start bit always reads 0.
- R3: A valid start raises busReq in the next cycle. No beat occurs in a cycle where the request has just risen, and no beat occurs before busGnt has been sampled high.
- R4: While it holds the bus, the engine moves one word per cycle and steps the address by DATA_W/8 each beat. Direction 0 reads devRData and writes it to memory (memWe=1, devRdEn=1). Direction 1 reads memRData and presents it on devWData (devWrEn=1, memWe=0).
- R5: A burst never crosses a PAGE_BYTES boundary. After a beat on the last word of a page that is not the last word of the block, busReq is low for exactly one cycle, then rises again, and the transfer resumes after the next grant.
- R6: busy reads 1 from the cycle after a valid start. In the cycle after the final beat, busy reads 0, done reads 1 and busReq is low.
- R7: A start is rejected when the byte count is zero, when the address is not word-aligned, or when the count is not a multiple of the word size. A rejected start sets error, makes no bus request and moves no data.
- R8: irq equals interrupt-enable AND (done OR error). It stays high until software clears the flag.
- R9: Writing 1 to status bit1 clears done, and writing 1 to bit2 clears error. If a completion sets done in the same cycle as such a clear, the set wins.
- R10: While busy is high, writes to the address, count and control words are ignored, including a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register word select |
| regWData | input | ADDR_W | Register write data |
| regRdData | output | ADDR_W | Register read data (combinational from regSel) |
| irq | output | 1 | Level interrupt to the processor |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant from the arbiter |
| memEn | output | 1 | Memory beat valid this cycle |
| memWe | output | 1 | Memory write (1) or read (0) for the beat |
| memAddr | output | ADDR_W | Byte address of the beat |
| memWData | output | DATA_W | Data written to memory |
| memRData | input | DATA_W | Data read from memory in the same cycle |
| devRdEn | output | 1 | Word taken from the device port |
| devRData | input | DATA_W | Device word available for reading |
| devWrEn | output | 1 | Word delivered to the device port |
| devWData | output | DATA_W | Word delivered to the device |

## Verification
The two actions that can fall in one cycle are a software write-one-to-clear of the done flag and the final beat of a new block, which sets done. The bench leaves done set from an earlier block and starts another. It watches memAddr for the last word of the block and drives the status clear into that same cycle. It then expects done to read 1 and irq to stay high. The cycle-level reference model predicts the outcome from the priority rule alone, and the status word, the request line and the beat signals are compared with it on every clock.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } dmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic beat;
    logic setDone;
    logic setErr;
    logic busy;
  } dmaStrobe_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_GO  = 0;
  localparam int CTRL_DIR = 1;
  localparam int CTRL_IE  = 2;

  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;
  localparam int STAT_ERR  = 2;
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWData,
  output logic [ADDR_W-1:0] regRdData,
  input  dmaStrobe_t        strobe,
  output logic              goReq,
  output logic              startBad,
  output logic              lastBeat,
  output logic              pageEnd,
  output logic              irq,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              devRdEn,
  input  logic [DATA_W-1:0] devRData,
  output logic              devWrEn,
  output logic [DATA_W-1:0] devWData
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] BEAT_A = ADDR_W'(BEAT_BYTES);
  localparam logic [LEN_W-1:0]  BEAT_L = LEN_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  lenReg;
  logic              dirReg;
  logic              ieReg;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic              doneFlag;
  logic              errFlag;
  logic              clrDone;
  logic              clrErr;
  logic              misAligned;

  // start decode and status clears
  assign goReq   = regWr && (regSel == SEL_CTRL) && regWData[CTRL_GO];
  assign clrDone = regWr && (regSel == SEL_STAT) && regWData[STAT_DONE];
  assign clrErr  = regWr && (regSel == SEL_STAT) && regWData[STAT_ERR];

  generate
    if (BEAT_SHIFT > 0) begin : g_align
      assign misAligned = (|addrReg[BEAT_SHIFT-1:0]) || (|lenReg[BEAT_SHIFT-1:0]);
    end else begin : g_noalign
      assign misAligned = 1'b0;
    end
  endgenerate

  assign startBad = (lenReg == '0) || misAligned;
  assign lastBeat = (remLen == BEAT_L);
  assign pageEnd  = &curAddr[PAGE_SHIFT-1:BEAT_SHIFT];

  // programming registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      lenReg  <= '0;
      dirReg  <= 1'b0;
      ieReg   <= 1'b0;
    end else if (regWr && !strobe.busy) begin
      case (regSel)
        SEL_ADDR: addrReg <= regWData;
        SEL_LEN:  lenReg  <= regWData[LEN_W-1:0];
        SEL_CTRL: begin
          dirReg <= regWData[CTRL_DIR];
          ieReg  <= regWData[CTRL_IE];
        end
        default: ;
      endcase
    end
  end

  // working address and remaining count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
    end else if (strobe.loadStart) begin
      curAddr <= addrReg;
      remLen  <= lenReg;
    end else if (strobe.beat) begin
      curAddr <= curAddr + BEAT_A;
      remLen  <= remLen - BEAT_L;
    end
  end

  // sticky flags: a set wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      doneFlag <= strobe.setDone || (doneFlag && !clrDone);
      errFlag  <= strobe.setErr  || (errFlag  && !clrErr);
    end
  end

  assign irq = ieReg && (doneFlag || errFlag);

  always_comb begin
    regRdData = '0;
    case (regSel)
      SEL_ADDR: regRdData = addrReg;
      SEL_LEN:  regRdData = {{(ADDR_W-LEN_W){1'b0}}, lenReg};
      SEL_CTRL: begin
        regRdData[CTRL_DIR] = dirReg;
        regRdData[CTRL_IE]  = ieReg;
      end
      default: begin
        regRdData[STAT_BUSY] = strobe.busy;
        regRdData[STAT_DONE] = doneFlag;
        regRdData[STAT_ERR]  = errFlag;
      end
    endcase
  end

  // beat steering
  assign memEn    = strobe.beat;
  assign memWe    = strobe.beat && !dirReg;
  assign devRdEn  = strobe.beat && !dirReg;
  assign devWrEn  = strobe.beat && dirReg;
  assign memAddr  = curAddr;
  assign memWData = devRData;
  assign devWData = memRData;
endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goReq,
  input  logic       startBad,
  input  logic       lastBeat,
  input  logic       pageEnd,
  input  logic       busGnt,
  output logic       busReq,
  output dmaStrobe_t strobe
);
  dmaState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    strobe.busy = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (goReq) begin
          if (startBad) begin
            strobe.setErr = 1'b1;
          end else begin
            strobe.loadStart = 1'b1;
            stateNxt = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (busGnt) stateNxt = ST_XFER;
      end
      ST_XFER: begin
        strobe.beat = 1'b1;
        if (lastBeat) begin
          strobe.setDone = 1'b1;
          stateNxt = ST_IDLE;
        end else if (pageEnd) begin
          stateNxt = ST_GAP;
        end
      end
      default: stateNxt = ST_REQ;
    endcase
  end

  assign busReq = (state == ST_REQ) || (state == ST_XFER);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWData,
  output logic [ADDR_W-1:0] regRdData,
  output logic              irq,
  output logic              busReq,
  input  logic              busGnt,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              devRdEn,
  input  logic [DATA_W-1:0] devRData,
  output logic              devWrEn,
  output logic [DATA_W-1:0] devWData
);
  dmaStrobe_t strobe;
  logic goReq, startBad, lastBeat, pageEnd;

  dma_control ctrlI (
    .clk(clk), .rstN(rstN), .goReq(goReq), .startBad(startBad),
    .lastBeat(lastBeat), .pageEnd(pageEnd), .busGnt(busGnt),
    .busReq(busReq), .strobe(strobe)
  );

  dma_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) dpI (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWData(regWData), .regRdData(regRdData), .strobe(strobe),
    .goReq(goReq), .startBad(startBad), .lastBeat(lastBeat),
    .pageEnd(pageEnd), .irq(irq), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
    .devRdEn(devRdEn), .devRData(devRData), .devWrEn(devWrEn),
    .devWData(devWData)
  );
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic              busReq,
  input logic              memEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              irq
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

  // R5
  page_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && (&memAddr[PAGE_SHIFT-1:BEAT_SHIFT])) |=> (!memEn && !busReq));

  // R3
  req_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> !memEn);

  // R4
  beat_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> busReq);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && $past(memEn)) |-> (memAddr == $past(memAddr) + ADDR_W'(BEAT_BYTES)));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !regWr) |=> irq);
endmodule

bind dma_engine dma_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
) chkI (
  .clk(clk), .rstN(rstN), .regWr(regWr), .busReq(busReq),
  .memEn(memEn), .memAddr(memAddr), .irq(irq)
);

// File: tb/sim_dma_engine.sv
`timescale 1ns/1ps
module sim_dma_engine;
  localparam int PAGE = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [1:0] regSel = 2'd3;
  logic [31:0] regWData = '0;
  logic [31:0] regRdData;
  logic irq, busReq, busGnt, memEn, memWe, devRdEn, devWrEn;
  logic [31:0] memAddr, memWData, memRData, devRData, devWData;

  always #10 clk = ~clk;

  dma_engine #(.ADDR_W(32), .DATA_W(32), .LEN_W(16), .PAGE_BYTES(PAGE)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWData(regWData), .regRdData(regRdData), .irq(irq),
    .busReq(busReq), .busGnt(busGnt), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
    .devRdEn(devRdEn), .devRData(devRData), .devWrEn(devWrEn),
    .devWData(devWData)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  // environment: arbiter, memory, device
  int gntDelay = 0;
  int reqAge = 0;
  logic [31:0] mem [0:255];
  int devIdx = 0;
  logic [31:0] devGot [$];
  int reqRises = 0;
  logic prevReq = 1'b0;

  assign busGnt   = busReq && (reqAge >= gntDelay);
  assign memRData = mem[memAddr[9:2]];
  assign devRData = 32'hD000_0000 + devIdx;

  always @(posedge clk) begin
    reqAge <= busReq ? reqAge + 1 : 0;
    prevReq <= busReq;
    if (rstN && busReq && !prevReq) reqRises <= reqRises + 1;
    if (memEn && memWe) mem[memAddr[9:2]] <= memWData;
    if (devRdEn) devIdx <= devIdx + 1;
    if (devWrEn) devGot.push_back(devWData);
  end

  // behavioural reference model, one step per clock
  int mPh, oPh, mL, oL, mRem, oRem;
  logic [31:0] mA, oA, mCur, oCur;
  bit mDir, mIe, mDone, mErr, sDone, sErr, clr;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mA = 0; mL = 0; mDir = 0; mIe = 0; mDone = 0; mErr = 0; mCur = 0; mRem = 0;
    end else begin
      oPh = mPh; oA = mA; oL = mL; oCur = mCur; oRem = mRem; sDone = 0; sErr = 0;
      if (regWr && oPh == 0) begin
        if (regSel == 0) mA = regWData;
        else if (regSel == 1) mL = int'(regWData[15:0]);
        else if (regSel == 2) begin mDir = regWData[1]; mIe = regWData[2]; end
      end
      case (oPh)
        0: if (regWr && regSel == 2 && regWData[0]) begin
             if (oL == 0 || oA[1:0] != 0 || (oL % 4) != 0) sErr = 1;
             else begin mCur = oA; mRem = oL; mPh = 1; end
           end
        1: if (busGnt) mPh = 2;
        2: begin
             mCur = oCur + 4; mRem = oRem - 4;
             if (oRem == 4) begin mPh = 0; sDone = 1; end
             else if ((oCur & (PAGE - 1)) == PAGE - 4) mPh = 3;
           end
        default: mPh = 1;
      endcase
      clr = regWr && regSel == 3;
      mDone = sDone || (mDone && !(clr && regWData[1]));
      mErr  = sErr  || (mErr  && !(clr && regWData[2]));
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(busReq == (mPh == 1 || mPh == 2), "R5 busReq", {31'b0, busReq}, {31'b0, (mPh == 1 || mPh == 2)});
      chk(memEn == (mPh == 2), "R3 memEn", {31'b0, memEn}, {31'b0, (mPh == 2)});
      if (mPh == 2) begin
        chk(memAddr == mCur, "R4 memAddr", memAddr, mCur);
        chk(memWe == !mDir && devRdEn == !mDir && devWrEn == mDir, "R4 steering",
            {29'b0, memWe, devRdEn, devWrEn}, {29'b0, !mDir, !mDir, mDir});
      end
      chk(irq == (mIe && (mDone || mErr)), "R8 irq", {31'b0, irq}, {31'b0, (mIe && (mDone || mErr))});
      if (regSel == 3)
        chk(regRdData == {29'b0, mErr, mDone, mPh != 0}, "R6 status", regRdData,
            {29'b0, mErr, mDone, mPh != 0});
    end
  end

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #2;
    regWr = 1'b1; regSel = sel; regWData = d;
    @(posedge clk); #2;
    regWr = 1'b0; regSel = 2'd3; regWData = '0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] d);
    @(posedge clk); #2;
    regSel = sel;
    #5 d = regRdData;
    @(posedge clk); #2;
    regSel = 2'd3;
  endtask

  task automatic waitIdle();
    @(posedge clk); #2 regSel = 2'd3;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (regRdData[0] == 1'b0) break;
    end
  endtask

  task automatic startBlock(input logic [31:0] a, input logic [31:0] n, input logic [31:0] ctl);
    regWrite(2'd0, a);
    regWrite(2'd1, n);
    regWrite(2'd2, ctl | 32'h1);
  endtask

  bit timedOut = 0;
  initial begin
    repeat (200000) @(posedge clk);
    timedOut = 1;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int base, rises;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      regRead(s[1:0], rd);
      chk(rd == 0, "R1 register after reset", rd, 0);
    end
    chk(!busReq && !irq && !memEn, "R1 outputs after reset", {29'b0, busReq, irq, memEn}, 0);

    // R2 register map readback, start bit reads zero
    regWrite(2'd0, 32'h0000_0120);
    regWrite(2'd1, 32'h0000_0010);
    regWrite(2'd2, 32'h0000_0006);
    regRead(2'd0, rd); chk(rd == 32'h120, "R2 address word", rd, 32'h120);
    regRead(2'd1, rd); chk(rd == 32'h10, "R2 count word", rd, 32'h10);
    regRead(2'd2, rd); chk(rd == 32'h6, "R2 control word", rd, 32'h6);

    // R3 R4 R6 device-to-memory inside one page, delayed grant
    gntDelay = 2;
    base = devIdx;
    startBlock(32'h100, 32'd16, 32'h4);
    regRead(2'd3, rd); chk(rd[0] == 1'b1, "R6 busy after start", rd, 32'h1);
    waitIdle();
    for (int i = 0; i < 4; i++)
      chk(mem[64 + i] == 32'hD000_0000 + base + i, "R4 dev->mem word", mem[64 + i], 32'hD000_0000 + base + i);
    regRead(2'd3, rd); chk(rd == 32'h2, "R6 done after block", rd, 32'h2);
    chk(irq == 1'b1, "R8 irq on done", {31'b0, irq}, 1);

    // R9 clear done, R8 irq falls
    regWrite(2'd3, 32'h2);
    regRead(2'd3, rd); chk(rd == 0, "R9 done cleared", rd, 0);
    chk(irq == 1'b0, "R8 irq after clear", {31'b0, irq}, 0);

    // R5 crossing one page boundary: two requests
    gntDelay = 1;
    rises = reqRises;
    base = devIdx;
    startBlock(32'h38, 32'd32, 32'h4);
    waitIdle();
    repeat (2) @(posedge clk);
    chk(reqRises - rises == 2, "R5 requests for two pages", reqRises - rises, 2);
    for (int i = 0; i < 8; i++)
      chk(mem[14 + i] == 32'hD000_0000 + base + i, "R5 data across page", mem[14 + i], 32'hD000_0000 + base + i);

    // R4 memory-to-device, done left set afterwards
    regWrite(2'd3, 32'h2);
    devGot.delete();
    startBlock(32'h38, 32'd32, 32'h6);
    waitIdle();
    repeat (2) @(posedge clk);
    chk(devGot.size() == 8, "R4 device words delivered", devGot.size(), 8);
    for (int i = 0; i < 8 && i < devGot.size(); i++)
      chk(devGot[i] == mem[14 + i], "R4 mem->dev word", devGot[i], mem[14 + i]);

    // R9 completion set collides with a clear: set wins
    gntDelay = 0;
    startBlock(32'h200, 32'd12, 32'h4);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (memEn && memAddr == 32'h208) break;
    end
    regWr = 1'b1; regSel = 2'd3; regWData = 32'h2;
    @(posedge clk); #2;
    regWr = 1'b0; regWData = '0;
    regRead(2'd3, rd); chk(rd == 32'h2, "R9 set beats clear", rd, 32'h2);
    chk(irq == 1'b1, "R9 irq kept", {31'b0, irq}, 1);
    regWrite(2'd3, 32'h2);

    // R7 rejected starts
    rises = reqRises;
    startBlock(32'h102, 32'd8, 32'h4);
    regRead(2'd3, rd); chk(rd == 32'h4, "R7 unaligned address", rd, 32'h4);
    chk(irq == 1'b1, "R8 irq on error", {31'b0, irq}, 1);
    regWrite(2'd3, 32'h4);
    startBlock(32'h100, 32'd0, 32'h4);
    regRead(2'd3, rd); chk(rd == 32'h4, "R7 zero count", rd, 32'h4);
    regWrite(2'd3, 32'h4);
    startBlock(32'h100, 32'd6, 32'h4);
    regRead(2'd3, rd); chk(rd == 32'h4, "R7 odd count", rd, 32'h4);
    regWrite(2'd3, 32'h4);
    repeat (2) @(posedge clk);
    chk(reqRises == rises, "R7 no request on error", reqRises - rises, 0);

    // R10 writes ignored while busy
    gntDelay = 8;
    rises = reqRises;
    base = devIdx;
    startBlock(32'h300, 32'd8, 32'h4);
    regWrite(2'd0, 32'h3F0);
    regWrite(2'd1, 32'd4);
    regWrite(2'd2, 32'h3);
    waitIdle();
    repeat (3) @(posedge clk);
    regRead(2'd0, rd); chk(rd == 32'h300, "R10 address kept", rd, 32'h300);
    regRead(2'd1, rd); chk(rd == 32'd8, "R10 count kept", rd, 8);
    regRead(2'd2, rd); chk(rd == 32'h4, "R10 control kept", rd, 32'h4);
    chk(reqRises - rises == 1, "R10 second start ignored", reqRises - rises, 1);
    chk(mem[192] == 32'hD000_0000 + base && mem[193] == 32'hD000_0001 + base,
        "R10 data of first block", mem[193], 32'hD000_0001 + base);
    regWrite(2'd3, 32'h2);

    // R5 R8 four pages, interrupt disabled
    gntDelay = 1;
    rises = reqRises;
    startBlock(32'h0, 32'd256, 32'h0);
    waitIdle();
    repeat (2) @(posedge clk);
    chk(reqRises - rises == 4, "R5 four page requests", reqRises - rises, 4);
    regRead(2'd3, rd); chk(rd == 32'h2, "R6 done with ie off", rd, 32'h2);
    chk(irq == 1'b0, "R8 irq masked", {31'b0, irq}, 0);

    repeat (3) @(posedge clk);
    if (!timedOut) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule